// File: doc/BRIEF.md
# Flow-Controlled SPI Register Transaction Master

This block runs one register access at a time against a SPI peripheral that can stall the bus by holding off a ready bit. The host pulses a start strobe with a 16-bit register address, a direction and a byte count. The block checks the request. It then opens the bus and shifts out a four-byte command header. After the header it keeps clocking filler bytes until the peripheral reports ready, and then moves the payload.

Write bytes come from the host one at a time over a ready/valid handshake. Read bytes go back to the host one at a time, each with a one-cycle valid strobe, in the order they arrived. Every request ends with a one-cycle done pulse that carries a 2-bit status.

The controller is a seven-state machine:

- **IDLE** waits for start.
- **HDR** sends the header.
- **POLL** sends filler bytes while the peripheral is not ready.
- **WDAT** waits for a write byte from the host.
- **DATA** shifts one payload byte.
- **GAP** holds chip select for a half period after the last edge.
- **DONE** releases chip select and pulses done.

The transitions are:

- IDLE→DONE when the request is rejected.
- IDLE→HDR when the request is accepted.
- HDR→HDR after each of the first three header bytes.
- HDR→DATA or HDR→WDAT when the fourth header byte returns ready.
- HDR→POLL when the fourth header byte does not return ready.
- POLL→POLL while the peripheral is still not ready.
- POLL→DATA or POLL→WDAT when ready is seen.
- POLL→GAP when the retry limit is reached.
- WDAT→DATA once a host byte is accepted.
- DATA→WDAT (write) or DATA→DATA (read) between bytes.
- DATA→GAP after the last byte.
- GAP→DONE after the half period.
- DONE→IDLE.

Top module: `spi_regxact_master`

## Requirements
- R1: A request is rejected with status 2'b01 in these cases: a byte count of 0, a byte count above 128, or a read whose count is not 1, 2 or 4. A rejected request never asserts chip select and never toggles SCLK. Any other count from 1 to 128 is accepted for a write.
- R2: The first header byte has bit 7 set to 1 for a read and 0 for a write. Bits 6:0 of that byte hold the byte count minus one.
- R3: The second header byte is 8'hD4. The third header byte is address bits 15:8 and the fourth is address bits 7:0.
- R4: If bit 0 of the byte received during the fourth header byte is 1, the payload starts next and no filler byte is sent.
- R5: Otherwise the block sends 8'h00 filler bytes and checks bit 0 of each received byte. It stops after the first filler byte whose received bit 0 is 1.
- R6: If 50 filler bytes pass without a received 1, the block ends with status 2'b10 and sends no payload. A completed access reports status 2'b00.
- R7: Chip select (active low) falls once per accepted request. It stays low from the first header bit through the last byte and rises once, including after a timeout.
- R8: On a write, each payload byte is taken from wr_data when both wr_valid and wr_ready are high. The bytes go out on MOSI in order, most significant bit first.
- R9: On a read, MOSI carries 8'h00 during the payload. Each received byte appears on rd_data with a one-cycle rd_valid, in arrival order.
- R10: SPI mode 0 is used. SCLK idles low. Every SCLK high phase lasts exactly clk_div+1 system cycles, and every low phase lasts at least clk_div+1 cycles. MOSI only changes while SCLK is low.
- R11: At least clk_div+1 system cycles pass between the last falling SCLK edge and the rise of chip select.
- R12: busy is high from the accepted start until done. done is a single-cycle pulse, one per request. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | 8 | SCLK half period minus one, in system cycles |
| start | input | 1 | Request strobe, sampled when idle |
| is_read | input | 1 | 1 = read, 0 = write |
| reg_addr | input | 16 | Register address |
| xfer_len | input | 8 | Payload byte count |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 ok, 01 rejected request, 10 timeout |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | wr_data is valid |
| wr_ready | output | 1 | Block accepts a write byte this cycle |
| rd_data | output | 8 | Received payload byte |
| rd_valid | output | 1 | rd_data is valid for one cycle |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to peripheral |
| spi_miso | input | 1 | Serial data from peripheral |

## Verification
The hardest cases to reach sit on the retry-limit boundary. The peripheral can become ready on exactly the 50th filler byte, which must succeed, or on the 51st, which must time out with chip select released. The bench's peripheral model takes a per-request stall count that sets how many not-ready bytes it returns before its ready byte. Directed requests pin that count at 0, 1, 50 and 51, and the random requests draw it from a range that straddles the limit. Write stalls on the host side come from randomly withholding wr_valid.

// File: rtl/spi_regxact_pkg.sv
package spi_regxact_pkg;
    typedef enum logic [1:0] {
        STAT_OK      = 2'b00,
        STAT_BADLEN  = 2'b01,
        STAT_TIMEOUT = 2'b10
    } stat_e;

    typedef enum logic [2:0] {
        S_IDLE, S_HDR, S_POLL, S_WDAT, S_DATA, S_GAP, S_DONE
    } state_e;

    localparam logic [7:0] HDR_TAG = 8'hD4;
endpackage

// File: rtl/spi_regxact_shifter.sv
module spi_regxact_shifter #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             go,
    input  logic [7:0]       tx_byte,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic [7:0]       rx_byte,
    output logic             byte_done
);
    logic             active;
    logic [DIV_W-1:0] hcnt;
    logic [2:0]       bitn;
    logic [7:0]       sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active    <= 1'b0;
            hcnt      <= '0;
            bitn      <= '0;
            sh        <= '0;
            rx_byte   <= '0;
            sclk      <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (go) begin
                active <= 1'b1;
                sh     <= tx_byte;
                hcnt   <= '0;
                bitn   <= '0;
                sclk   <= 1'b0;
            end else if (active) begin
                if (hcnt == clk_div) begin
                    hcnt <= '0;
                    if (!sclk) begin
                        sclk    <= 1'b1;
                        rx_byte <= {rx_byte[6:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bitn == 3'd7) begin
                            active    <= 1'b0;
                            byte_done <= 1'b1;
                        end else begin
                            bitn <= bitn + 3'd1;
                            sh   <= {sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    hcnt <= hcnt + 1'b1;
                end
            end
        end
    end

    assign mosi = sh[7];
endmodule

// File: rtl/spi_regxact_master.sv
module spi_regxact_master
    import spi_regxact_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int LEN_W     = 8,
    parameter int MAX_LEN   = 128,
    parameter int RETRY_MAX = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             start,
    input  logic             is_read,
    input  logic [15:0]      reg_addr,
    input  logic [LEN_W-1:0] xfer_len,
    output logic             busy,
    output logic             done,
    output logic [1:0]       status,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             spi_cs_n,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    localparam int RW = $clog2(RETRY_MAX + 1);

    state_e           state;
    stat_e            stat_q;
    logic             rd_q, inflight, go, byte_done, req_ok;
    logic [15:0]      addr_q;
    logic [LEN_W-1:0] len_q, dcnt, lenm1;
    logic [1:0]       idx;
    logic [RW-1:0]    retry;
    logic [DIV_W-1:0] gap_cnt;
    logic [7:0]       tx, hdr_byte, rx;
    state_e           pay_state;

    spi_regxact_shifter #(.DIV_W(DIV_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .go(go), .tx_byte(tx),
        .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .rx_byte(rx),
        .byte_done(byte_done)
    );

    assign req_ok = (xfer_len != '0) && (xfer_len <= LEN_W'(MAX_LEN)) &&
                    (!is_read || xfer_len == LEN_W'(1) || xfer_len == LEN_W'(2) ||
                     xfer_len == LEN_W'(4));
    assign lenm1     = len_q - 1'b1;
    assign pay_state = rd_q ? S_DATA : S_WDAT;

    always_comb begin
        unique case (idx)
            2'd0:    hdr_byte = {rd_q, lenm1[6:0]};
            2'd1:    hdr_byte = HDR_TAG;
            2'd2:    hdr_byte = addr_q[15:8];
            default: hdr_byte = addr_q[7:0];
        endcase
    end

    // State register and transaction bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            stat_q   <= STAT_OK;
            rd_q     <= 1'b0;
            addr_q   <= '0;
            len_q    <= '0;
            dcnt     <= '0;
            idx      <= '0;
            retry    <= '0;
            gap_cnt  <= '0;
            inflight <= 1'b0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (go)             inflight <= 1'b1;
            else if (byte_done) inflight <= 1'b0;
            if (state != S_GAP) gap_cnt <= '0;
            unique case (state)
                S_IDLE: if (start) begin
                    rd_q   <= is_read;
                    len_q  <= xfer_len;
                    addr_q <= reg_addr;
                    idx    <= '0;
                    retry  <= '0;
                    dcnt   <= '0;
                    stat_q <= req_ok ? STAT_OK : STAT_BADLEN;
                    state  <= req_ok ? S_HDR : S_DONE;
                end
                S_HDR: if (byte_done) begin
                    idx <= idx + 2'd1;
                    if (idx == 2'd3) state <= rx[0] ? pay_state : S_POLL;
                end
                S_POLL: if (byte_done) begin
                    if (rx[0]) begin
                        state <= pay_state;
                    end else if (retry == RW'(RETRY_MAX - 1)) begin
                        stat_q <= STAT_TIMEOUT;
                        state  <= S_GAP;
                    end else begin
                        retry <= retry + 1'b1;
                    end
                end
                S_WDAT: if (wr_valid) state <= S_DATA;
                S_DATA: if (byte_done) begin
                    if (rd_q) begin
                        rd_valid <= 1'b1;
                        rd_data  <= rx;
                    end
                    if (dcnt == lenm1) begin
                        state <= S_GAP;
                    end else begin
                        dcnt  <= dcnt + 1'b1;
                        state <= pay_state;
                    end
                end
                S_GAP: if (gap_cnt == clk_div) state <= S_DONE;
                       else gap_cnt <= gap_cnt + 1'b1;
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        go       = 1'b0;
        tx       = 8'h00;
        wr_ready = 1'b0;
        unique case (state)
            S_HDR:  begin go = !inflight; tx = hdr_byte; end
            S_POLL: go = !inflight;
            S_WDAT: begin wr_ready = 1'b1; go = wr_valid; tx = wr_data; end
            S_DATA: go = rd_q && !inflight;
            default: ;
        endcase
    end

    assign spi_cs_n = (state == S_IDLE) || (state == S_DONE);
    assign busy     = (state != S_IDLE);
    assign done     = (state == S_DONE);
    assign status   = stat_q;
endmodule

// File: rtl/spi_regxact_checker.sv
module spi_regxact_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic [1:0] status,
    input logic       wr_ready,
    input logic       rd_valid,
    input logic       spi_cs_n,
    input logic       spi_sclk,
    input logic       spi_mosi
);
    AST_BADLEN_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'b01) |-> (spi_cs_n && $past(spi_cs_n))); // R1
    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status != 2'b11)); // R6
    AST_CS_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy); // R7
    AST_WRREADY_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !spi_cs_n); // R8
    AST_RDVALID_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !spi_cs_n); // R9
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk); // R10
    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R10
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R12
endmodule

bind spi_regxact_master spi_regxact_checker u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .status(status),
    .wr_ready(wr_ready), .rd_valid(rd_valid), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi)
);

// File: tb/spi_regxact_master_bench.sv
`timescale 1ns/1ps
module spi_regxact_master_bench;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic [7:0] clk_div = 8'd0;
    logic       start = 1'b0, is_read = 1'b0;
    logic [15:0] reg_addr = 16'h0;
    logic [7:0] xfer_len = 8'd1;
    logic       busy, done, wr_ready, rd_valid, spi_cs_n, spi_sclk, spi_mosi;
    logic [1:0] status;
    logic [7:0] wr_data = 8'h00, rd_data;
    logic       wr_valid = 1'b0, spi_miso = 1'b0;

    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    spi_regxact_master u_spi_regxact_master (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .start(start),
        .is_read(is_read), .reg_addr(reg_addr), .xfer_len(xfer_len),
        .busy(busy), .done(done), .status(status), .wr_data(wr_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data),
        .rd_valid(rd_valid), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // peripheral model state
    int         stall_g = 0;
    logic [7:0] rdbuf [256];
    logic [7:0] wbuf  [256];
    logic [7:0] mlog  [256];
    int nlog = 0, rxbits = 0, bitpos = 0, nout = 0, cs_falls = 0;
    logic [7:0] rxsh = 8'h00, cur = 8'h00;

    function automatic logic [7:0] periph_byte(int n);
        if (n < 3) return 8'h00;
        if (n <= 3 + stall_g) return {7'h55, (n - 3 == stall_g)};
        return rdbuf[(n - 4 - stall_g) & 255];
    endfunction

    always @(negedge spi_cs_n) begin
        bitpos = 0; nout = 0; rxbits = 0; cs_falls++;
        cur = periph_byte(0);
        spi_miso = cur[7];
    end
    always @(posedge spi_sclk) if (!spi_cs_n) begin
        rxsh = {rxsh[6:0], spi_mosi};
        rxbits++;
        if (rxbits == 8) begin
            if (nlog < 256) mlog[nlog] = rxsh;
            nlog++;
            rxbits = 0;
        end
    end
    always @(negedge spi_sclk) if (!spi_cs_n) begin
        bitpos++;
        if (bitpos == 8) begin
            bitpos = 0; nout++;
            cur = periph_byte(nout);
        end
        spi_miso = cur[7 - bitpos];
    end

    // port monitor, sampled mid-cycle
    logic [7:0] rlog [256];
    int nrd = 0, ndone = 0, cs_rises = 0, hi = 0, lo = 0, since_fall = 0;
    int bad_hi = 0, bad_lo = 0, bad_idle = 0, min_gap = 1000;
    logic [1:0] last_stat = 2'b11;
    logic prev_sclk = 1'b0, prev_cs = 1'b1;
    always @(negedge clk) begin
        if (rd_valid) begin rlog[nrd & 255] = rd_data; nrd++; end
        if (done) begin ndone++; last_stat = status; end
        if (spi_cs_n && spi_sclk) bad_idle++;
        if (spi_sclk) begin
            if (!prev_sclk && lo < clk_div + 1) bad_lo++;
            hi++;
        end else begin
            if (prev_sclk) begin
                if (hi != clk_div + 1) bad_hi++;
                hi = 0; lo = 0; since_fall = 0;
            end
            lo++; since_fall++;
        end
        if (!prev_cs && spi_cs_n) begin
            cs_rises++;
            if (since_fall < min_gap) min_gap = since_fall;
        end
        if (prev_cs && !spi_cs_n) lo = 0;
        prev_sclk = spi_sclk;
        prev_cs = spi_cs_n;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    bit xact_over = 1'b0;
    int wi = 0;

    task automatic feeder();
        wi = 0;
        while (!xact_over) begin
            bit hs;
            @(negedge clk);
            wr_valid = ($urandom % 4) != 0;
            wr_data  = wbuf[wi & 255];
            hs = wr_valid && wr_ready;
            @(posedge clk);
            if (hs) wi++;
        end
        wr_valid = 1'b0;
    endtask

    task automatic run(input bit rd, input logic [15:0] addr, input int len,
                       input int stall, input int div, input bit poke);
        bit valid, tmo;
        int p, exp_n, d0;
        stall_g = stall;
        for (int i = 0; i < 256; i++) begin
            rdbuf[i] = 8'($urandom);
            wbuf[i]  = 8'($urandom);
        end
        nlog = 0; nrd = 0; ndone = 0; cs_falls = 0; cs_rises = 0;
        bad_hi = 0; bad_lo = 0; bad_idle = 0; min_gap = 1000;
        xact_over = 1'b0;
        @(negedge clk);
        clk_div = 8'(div); is_read = rd; reg_addr = addr; xfer_len = 8'(len);
        start = 1'b1;
        fork feeder(); join_none
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (5) @(negedge clk);
            chk(busy == 1'b1, "R12 busy during request", busy, 1);
            is_read = ~rd; reg_addr = ~addr; xfer_len = 8'd2; start = 1'b1;
            @(negedge clk);
            start = 1'b0; is_read = rd; reg_addr = addr; xfer_len = 8'(len);
        end
        wait (ndone > 0);
        repeat (3) @(negedge clk);
        xact_over = 1'b1;
        repeat (3) @(negedge clk);

        valid = (len != 0) && (len <= 128) && (!rd || len == 1 || len == 2 || len == 4);
        tmo   = stall > 50;
        p     = (stall == 0) ? 0 : (tmo ? 50 : stall);
        chk(ndone == 1, "R12 one done pulse", ndone, 1);
        chk(busy == 1'b0, "R12 idle after done", busy, 0);
        if (!valid) begin
            chk(last_stat == 2'b01, "R1 rejected status", last_stat, 1);
            chk(cs_falls == 0 && nlog == 0, "R1 no bus activity", cs_falls + nlog, 0);
            return;
        end
        exp_n = 4 + p + (tmo ? 0 : len);
        chk(last_stat == (tmo ? 2'b10 : 2'b00), "R6 status", last_stat, tmo ? 2 : 0);
        chk(nlog == exp_n, "R5 bytes on MOSI", nlog, exp_n);
        chk(cs_falls == 1 && cs_rises == 1, "R7 single CS window", cs_falls * 10 + cs_rises, 11);
        chk(mlog[0] == {rd, 7'(len - 1)}, "R2 header byte 0", mlog[0], {rd, 7'(len - 1)});
        chk(mlog[1] == 8'hD4 && mlog[2] == addr[15:8] && mlog[3] == addr[7:0],
            "R3 header bytes 1-3", {mlog[1], mlog[2], mlog[3]}, {8'hD4, addr});
        for (int k = 0; k < p; k++)
            chk(mlog[4 + k] == 8'h00, stall == 0 ? "R4 filler" : "R5 filler zero", mlog[4 + k], 0);
        d0 = 4 + p;
        if (!tmo) begin
            for (int k = 0; k < len; k++) begin
                if (rd) chk(mlog[d0 + k] == 8'h00, "R9 MOSI zero on read", mlog[d0 + k], 0);
                else    chk(mlog[d0 + k] == wbuf[k], "R8 write byte", mlog[d0 + k], wbuf[k]);
            end
        end
        chk(nrd == ((rd && !tmo) ? len : 0), "R9 read byte count", nrd, (rd && !tmo) ? len : 0);
        if (rd && !tmo)
            for (int k = 0; k < len; k++)
                chk(rlog[k] == rdbuf[k], "R9 read byte", rlog[k], rdbuf[k]);
        chk(wi == ((!rd && !tmo) ? len : 0), "R8 write handshakes", wi, (!rd && !tmo) ? len : 0);
        chk(bad_hi == 0 && bad_lo == 0 && bad_idle == 0, "R10 SCLK timing",
            bad_hi + bad_lo + bad_idle, 0);
        chk(min_gap >= div + 1, "R11 CS release gap", min_gap, div + 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0 && busy === 1'b0 && done === 1'b0,
            "R12 reset state", {spi_cs_n, spi_sclk, busy, done}, 4'b1000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run(1'b1, 16'h0F12, 1,   0,  0, 1'b0);  // R4 immediate ready
        run(1'b0, 16'hA5C3, 2,   1,  1, 1'b0);  // R5 one stall
        run(1'b1, 16'h0024, 4,   50, 0, 1'b0);  // R5 ready on last allowed poll
        run(1'b0, 16'h3300, 1,   51, 0, 1'b0);  // R6 timeout
        run(1'b1, 16'h1234, 2,   55, 1, 1'b0);  // R6 read timeout
        run(1'b0, 16'hFFFF, 128, 0,  0, 1'b0);  // R1 longest write
        run(1'b0, 16'h0001, 129, 0,  0, 1'b0);  // R1 too long
        run(1'b0, 16'h0001, 0,   0,  0, 1'b0);  // R1 zero
        run(1'b1, 16'h0002, 3,   0,  0, 1'b0);  // R1 read of 3
        run(1'b0, 16'h0003, 3,   2,  2, 1'b0);  // R1 write of 3 accepted
        run(1'b1, 16'hBEEF, 4,   3,  3, 1'b1);  // R12 start while busy

        for (int t = 0; t < 20; t++) begin
            bit r;
            int l;
            r = 1'($urandom);
            if (r) begin
                int s = $urandom % 3;
                l = (s == 0) ? 1 : (s == 1) ? 2 : 4;
            end else begin
                l = 1 + ($urandom % 16);
            end
            run(r, 16'($urandom), l, $urandom % 56, $urandom % 3, 1'b0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule